// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block holds the configuration word of a frequency-shift-keying line modem. It also loads that word over a serial link. A host raises a register-select line and then sends one data bit per bit strobe, most significant bit first. When the select line drops, the block decides whether the transfer is valid. If it is, the new word is written into the register. If it is not, the register keeps its old contents. While the host shifts bits in, the block shifts the current register contents out on a readback line. A transfer therefore reads the register at the same time as it writes it.

The register has two lengths, chosen by one of its own bits.

- **Normal length (24 bits).** A transfer commits when it carries 24 bits or more, and only the last 24 bits are kept. A shorter transfer is discarded.
- **Extended length (48 bits).** A transfer commits only when it carries exactly 48 bits. This makes a stray toggle of the select line much less likely to corrupt the setup.

The decoded fields drive the rest of the modem as plain outputs.

Top module: `cfg_serial_loader`

## Requirements
- R1: A bit is taken only in a cycle where `cfg_sel` is high and `bit_en` is high. Strobes while `cfg_sel` is low are ignored. The register changes only in the cycle after a falling edge of `cfg_sel`.
- R2: With bit 21 clear (normal length), a transfer of 24 bits or more writes its last 24 received bits into register bits 23:0. Register bits 47:24 keep their value.
- R3: With bit 21 clear, a transfer of fewer than 24 bits, including none, leaves the whole register unchanged.
- R4: Register bit 21 set means extended length. The length rule for each transfer is taken from bit 21 as it stood before that transfer.
- R5: With bit 21 set, a transfer of exactly 48 bits writes all 48 register bits. Any other count, shorter or longer, leaves the register unchanged.
- R6: Bits arrive most significant first. The last bit received lands in register bit 0.
- R7: The field outputs are:
  - `chan` = bits 2:0
  - `baud` = bits 4:3
  - `dev` = bit 5
  - `wd_en` = bit 6
  - `tmo` = bits 8:7
  - `hdr_en` = bit 18
  - `hdr_len16` = bit 20
  - `ext_mode` = bit 21
  - `hi_sens` = bit 22
  - `filt_en` = bit 23
  - `ext_word` = bits 47:24
- R8: From the cycle after `cfg_sel` rises, `rd_bit` shows the register as it stood at that rise, most significant bit first. It advances one bit per taken strobe. In normal length it starts at bit 23; in extended length it starts at bit 47. `rd_bit` is 0 while `cfg_sel` is low.
- R9: Reset loads 0x000000000062. This gives `chan`=010 (86 kHz), `baud`=00 (600 baud), `dev`=1, `wd_en`=1, `tmo`=00, normal length and normal sensitivity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Register-select; high frames a transfer |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| bit_in | input | 1 | Serial write data, MSB first |
| rd_bit | output | 1 | Serial readback data |
| chan | output | 3 | Carrier channel code |
| baud | output | 2 | Baud rate code |
| dev | output | 1 | Frequency deviation select |
| wd_en | output | 1 | Watchdog enable |
| tmo | output | 2 | Transmit timeout code |
| hdr_en | output | 1 | Header recognition enable |
| hdr_len16 | output | 1 | Header length is 16 bits when set |
| ext_mode | output | 1 | Extended 48-bit register length |
| hi_sens | output | 1 | High receive sensitivity |
| filt_en | output | 1 | Input filter enable |
| ext_word | output | 24 | Upper register half |

## Verification
A bit strobe can arrive in the same cycle that the select line drops. That cycle both ends the transfer and judges its length.

The bench provokes this case in extended length. It sends exactly 48 bits and holds `bit_en` high with `bit_in` at 1 in the falling cycle. If that strobe were counted, the count would reach 49 and the write would be aborted. The bench therefore judges the case by checking that the decoded fields show the 48-bit value and not the old one.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int NORM_W  = 24;
    localparam int EXT_W   = 48;

    // field positions decoded by neighbouring logic
    localparam int CH_LO   = 0;
    localparam int BD_LO   = 3;
    localparam int DEV_B   = 5;
    localparam int WD_B    = 6;
    localparam int TMO_LO  = 7;
    localparam int HDR_B   = 18;
    localparam int HLEN_B  = 20;
    localparam int EXT_B   = 21;
    localparam int SENS_B  = 22;
    localparam int FILT_B  = 23;

    localparam logic [EXT_W-1:0] RST_VAL = 48'h0000_0000_0062;

    typedef struct packed {
        logic [2:0]  chan;
        logic [1:0]  baud;
        logic        dev;
        logic        wd_en;
        logic [1:0]  tmo;
        logic        hdr_en;
        logic        hdr_len16;
        logic        ext_mode;
        logic        hi_sens;
        logic        filt_en;
        logic [23:0] ext_word;
    } cfg_fields_t;

endpackage

// File: rtl/cfg_shift_ctl.sv
module cfg_shift_ctl #(
    parameter int W  = 48,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sel,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic [W-1:0]  load_val,
    output logic          fall,
    output logic [CW-1:0] cnt,
    output logic [W-1:0]  shreg,
    output logic          rd_bit
);
    localparam logic [CW-1:0] SAT = CW'(W + 1);

    typedef struct packed {
        logic          sel;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic [W-1:0]  rd;
    } st_t;

    st_t st_d, st_q;
    logic start, take;

    always_comb begin
        start = cfg_sel & ~st_q.sel;
        take  = cfg_sel & bit_en;
        st_d      = st_q;
        st_d.sel  = cfg_sel;
        if (start) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
            st_d.rd  = load_val;
        end
        if (take) begin
            if (st_d.cnt != SAT) st_d.cnt = st_d.cnt + 1'b1;
            st_d.sh = {st_d.sh[W-2:0], bit_in};
            st_d.rd = {st_d.rd[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall   = st_q.sel & ~cfg_sel;
    assign cnt    = st_q.cnt;
    assign shreg  = st_q.sh;
    assign rd_bit = st_q.sel & cfg_sel & st_q.rd[W-1];

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sel) |=> (st_q.sh == $past(st_q.sh) && st_q.cnt == $past(st_q.cnt))); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel && cfg_sel && bit_en && st_q.cnt != SAT) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R1

endmodule

// File: rtl/cfg_field_dec.sv
module cfg_field_dec
    import cfg_pkg::*;
(
    input  logic [EXT_W-1:0] word,
    output cfg_fields_t      f
);
    logic unused_bits;

    always_comb begin
        f.chan      = word[CH_LO +: 3];
        f.baud      = word[BD_LO +: 2];
        f.dev       = word[DEV_B];
        f.wd_en     = word[WD_B];
        f.tmo       = word[TMO_LO +: 2];
        f.hdr_en    = word[HDR_B];
        f.hdr_len16 = word[HLEN_B];
        f.ext_mode  = word[EXT_B];
        f.hi_sens   = word[SENS_B];
        f.filt_en   = word[FILT_B];
        f.ext_word  = word[EXT_W-1:NORM_W];
    end

    assign unused_bits = ^{word[17:9], word[19]};

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        bit_en,
    input  logic        bit_in,
    output logic        rd_bit,
    output logic [2:0]  chan,
    output logic [1:0]  baud,
    output logic        dev,
    output logic        wd_en,
    output logic [1:0]  tmo,
    output logic        hdr_en,
    output logic        hdr_len16,
    output logic        ext_mode,
    output logic        hi_sens,
    output logic        filt_en,
    output logic [23:0] ext_word
);
    localparam int CW = $clog2(EXT_W + 2);
    localparam logic [CW-1:0] NORM_C = CW'(NORM_W);
    localparam logic [CW-1:0] EXT_C  = CW'(EXT_W);

    logic [EXT_W-1:0] reg_d, reg_q, load_val, shreg;
    logic [CW-1:0]    cnt;
    logic             fall, ext_q, ok_norm, ok_ext;
    cfg_fields_t      fld;

    cfg_shift_ctl #(.W(EXT_W), .CW(CW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .load_val (load_val),
        .fall     (fall),
        .cnt      (cnt),
        .shreg    (shreg),
        .rd_bit   (rd_bit)
    );

    always_comb begin
        ext_q    = reg_q[EXT_B];
        load_val = ext_q ? reg_q : {reg_q[NORM_W-1:0], {(EXT_W-NORM_W){1'b0}}};
        ok_norm  = fall & ~ext_q & (cnt >= NORM_C);
        ok_ext   = fall &  ext_q & (cnt == EXT_C);
        reg_d    = reg_q;
        if (ok_norm) reg_d = {reg_q[EXT_W-1:NORM_W], shreg[NORM_W-1:0]};
        if (ok_ext)  reg_d = shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= RST_VAL;
        else        reg_q <= reg_d;
    end

    cfg_field_dec u_dec (.word(reg_q), .f(fld));

    assign chan      = fld.chan;
    assign baud      = fld.baud;
    assign dev       = fld.dev;
    assign wd_en     = fld.wd_en;
    assign tmo       = fld.tmo;
    assign hdr_en    = fld.hdr_en;
    assign hdr_len16 = fld.hdr_len16;
    assign ext_mode  = fld.ext_mode;
    assign hi_sens   = fld.hi_sens;
    assign filt_en   = fld.filt_en;
    assign ext_word  = fld.ext_word;

    AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall) |=> (reg_q == $past(reg_q))); // R1
    AST_NORM_KEEP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !reg_q[EXT_B] && cnt >= NORM_C) |=>
        (reg_q == {$past(reg_q[EXT_W-1:NORM_W]), $past(shreg[NORM_W-1:0])})); // R2
    AST_NORM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !reg_q[EXT_B] && cnt < NORM_C) |=> (reg_q == $past(reg_q))); // R3
    AST_EXT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && reg_q[EXT_B] && cnt != EXT_C) |=> (reg_q == $past(reg_q))); // R5
    AST_EXT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && reg_q[EXT_B] && cnt == EXT_C) |=> (reg_q == $past(shreg))); // R5

endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sel = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
    logic rd_bit, dev, wd_en, hdr_en, hdr_len16, ext_mode, hi_sens, filt_en;
    logic [2:0] chan;
    logic [1:0] baud, tmo;
    logic [23:0] ext_word;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .bit_en(bit_en), .bit_in(bit_in),
        .rd_bit(rd_bit), .chan(chan), .baud(baud), .dev(dev), .wd_en(wd_en), .tmo(tmo),
        .hdr_en(hdr_en), .hdr_len16(hdr_len16), .ext_mode(ext_mode), .hi_sens(hi_sens),
        .filt_en(filt_en), .ext_word(ext_word)
    );

    localparam logic [47:0] MASK = 48'hFFFFFF_F401FF;

    typedef struct packed {
        logic [6:0]  n;
        logic [63:0] data;
        logic [47:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{n: 7'd24, data: 64'h0000_0000_0000_00A5, exp: 48'h0000_0000_00A5, req: 4'd2}, // R2 R6 R7
        '{n: 7'd30, data: 64'h0000_0000_3CD0_015E, exp: 48'h0000_00D0_015E, req: 4'd2}, // R2 keep last 24
        '{n: 7'd10, data: 64'h0000_0000_0000_03FF, exp: 48'h0000_00D0_015E, req: 4'd3}, // R3 short
        '{n: 7'd0,  data: 64'h0,                   exp: 48'h0000_00D0_015E, req: 4'd3}, // R3 empty
        '{n: 7'd23, data: 64'h0000_0000_007F_FFFF, exp: 48'h0000_00D0_015E, req: 4'd3}, // R3 one short
        '{n: 7'd24, data: 64'h0000_0000_0024_0033, exp: 48'h0000_0024_0033, req: 4'd4}, // R4 enter extended
        '{n: 7'd24, data: 64'h0000_0000_0000_0001, exp: 48'h0000_0024_0033, req: 4'd5}, // R5 short in ext
        '{n: 7'd49, data: 64'h0001_FFFF_FFFF_FFFF, exp: 48'h0000_0024_0033, req: 4'd5}, // R5 long in ext
        '{n: 7'd48, data: 64'h0000_5A5A_5AA4_0103, exp: 48'h5A5A_5AA4_0103, req: 4'd5}, // R5 exact
        '{n: 7'd48, data: 64'h0000_1234_5600_0042, exp: 48'h1234_5600_0042, req: 4'd4}, // R4 leave extended
        '{n: 7'd24, data: 64'h0000_0000_0000_0011, exp: 48'h1234_5600_0011, req: 4'd2}  // R2 upper kept
    };

    function automatic logic [47:0] observed();
        return {ext_word, filt_en, hi_sens, ext_mode, hdr_len16, 1'b0, hdr_en, 9'b0,
                tmo, wd_en, dev, baud, chan};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one transfer of n bits, MSB first; rd collects readback bits
    task automatic frame(input int n, input logic [63:0] d, input bit strobe_at_fall,
                         output logic [63:0] rd);
        rd = '0;
        @(negedge clk);
        cfg_sel = 1'b1; bit_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd = {rd[62:0], rd_bit};
            bit_en = 1'b1;
            bit_in = d[n-1-i];
        end
        @(negedge clk);
        cfg_sel = 1'b0;
        bit_en = strobe_at_fall;
        bit_in = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; bit_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(observed() == 48'h62, "R9 reset word", 64'(observed()), 64'h62);
        chk(rd_bit == 1'b0, "R8 rd idle", 64'(rd_bit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 strobes with select low are ignored
        bit_en = 1'b1; bit_in = 1'b1;
        repeat (30) @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
        chk(observed() == 48'h62, "R1 idle strobes", 64'(observed()), 64'h62);
        chk(chan == 3'b010 && baud == 2'b00 && dev && wd_en && !ext_mode && !hi_sens,
            "R9 reset fields", 64'(observed()), 64'h62);

        for (int v = 0; v < NV; v++) begin
            frame(int'(VECS[v].n), VECS[v].data, 1'b0, rd);
            chk((observed() & MASK) == (VECS[v].exp & MASK),
                $sformatf("R%0d vector %0d", VECS[v].req, v),
                64'(observed()), 64'(VECS[v].exp & MASK));
        end
        // R7 direct field view of 0x123456000011
        chk(chan == 3'd1 && baud == 2'd2 && ext_word == 24'h123456, "R7 fields",
            64'(observed()), 64'h123456000011);

        // R8 normal readback: write back the same value
        frame(24, 64'h11, 1'b0, rd);
        chk(rd[23:0] == 24'h000011, "R8 normal readback", rd, 64'h11);
        // enter extended, then read 48 bits
        frame(24, 64'h200000, 1'b0, rd);
        chk(ext_mode == 1'b1, "R4 ext on", 64'(ext_mode), 1);
        frame(48, 64'h1234_5620_0000, 1'b0, rd);
        chk(rd[47:0] == 48'h1234_5620_0000, "R8 ext readback", rd, 64'h123456200000);

        // R1 strobe coinciding with select fall is not counted
        frame(48, 64'h0000_0000_0062, 1'b1, rd);
        chk(observed() == 48'h62, "R1 strobe at fall", 64'(observed()), 64'h62);
        chk(rd_bit == 1'b0, "R8 rd low after frame", 64'(rd_bit), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule